// File: doc/BRIEF.md
# Chroma Subcarrier Phase Generator

This block is a 32-bit numerically controlled oscillator. It produces the running colour subcarrier phase for a composite video encoder, and it is clocked by the line-locked pixel clock. The phase increment is the subcarrier-to-pixel-clock frequency ratio scaled by 2^32 and rounded, with both frequencies counted in multiples of the line rate. For example, 227.5 / 1716 gives 0x21F07C1F on 525-line systems, and 283.7516 / 1728 gives 0x2A098ACB on 625-line systems.

Software loads the increment one byte at a time over a byte-wide write port, using four consecutive subaddresses. The three lower bytes wait in a shadow register. The increment the accumulator uses changes only when the top byte arrives, so the accumulator never steps by a half-written word. On every clock the accumulator adds the working increment, modulo 2^32. A synchronous clear input, aligned by the system to a field or colour-sequence boundary, returns the phase to zero. The upper accumulator bits go out to a later sine lookup, and the full accumulator is also visible on a port.

Top module: `subcarrier_nco`

## Requirements
- R1: After reset the accumulator, the phase output and the working increment are all zero, so with no writes the accumulator stays at zero.
- R2: With the clear input low, each rising clock edge sets the accumulator to its previous value plus the working increment, modulo 2^32.
- R3: The increment bytes live at subaddresses 0x63, 0x64, 0x65 and 0x66. Subaddress 0x63 holds bits 7:0 and subaddress 0x66 holds bits 31:24.
- R4: Writes to 0x63, 0x64 or 0x65 alone leave the working increment, and therefore the accumulator step, unchanged.
- R5: A write to 0x66 loads the whole working increment at that clock edge: the written byte as the top byte, with the three shadowed bytes below it. The accumulator step at that same edge still uses the old increment, and the step at the next edge uses the new one.
- R6: When the clear input is high at a clock edge, the accumulator becomes zero at that edge, and clearing overrides the addition.
- R7: The phase output equals accumulator bits 31:22.
- R8: Writes to any subaddress outside 0x63..0x66 have no effect on the increment or the accumulator.
- R9: With the 525-line increment, the accumulator advances by 1716 times the increment over 1716 clocks. This lands within 858 counts of the ideal 227.5 × 2^32 taken modulo 2^32. The 625-line increment over 1728 clocks stays likewise within 864 counts of 283.7516 × 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 8 | Write subaddress |
| wrData | input | 8 | Write data byte |
| phaseClr | input | 1 | Synchronous phase clear |
| phaseAcc | output | 32 | Full phase accumulator |
| phaseOut | output | 10 | Upper phase bits for the sine lookup |

## Verification
The assertions expect that the write strobe, subaddress and data are stable and known across each rising edge. They also expect a clear to be a level sampled at the edge, not a pulse between edges. The bench drives every input on the falling edge and keeps it for a whole cycle, so each write and each clear lands on exactly one rising edge. The accumulator is sampled on the falling edge that follows, so every observed value reflects a known number of completed steps.

// File: rtl/snco_pkg.sv
package snco_pkg;
  parameter int ACC_W  = 32;
  parameter int BYTE_W = 8;
  localparam int BYTES = ACC_W / BYTE_W;

  typedef struct packed {
    logic [BYTES-1:0] byteWe;  // one strobe per increment byte
    logic             commit;  // top byte written: load working increment
    logic             clear;   // phase clear
  } sncoStrobes_t;
endpackage

// File: rtl/snco_ctrl.sv
module snco_ctrl
  import snco_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h63
) (
  input  logic         wrEn,
  input  logic [7:0]   wrAddr,
  input  logic         phaseClr,
  output sncoStrobes_t strobes
);
  logic [BYTES-1:0] hit;

  for (genvar i = 0; i < BYTES; i++) begin : g_dec
    assign hit[i] = wrEn && (wrAddr == 8'(BASE_ADDR + i));
  end

  always_comb begin
    strobes.byteWe = hit;
    strobes.commit = hit[BYTES-1];
    strobes.clear  = phaseClr;
  end
endmodule

// File: rtl/snco_dp.sv
module snco_dp
  import snco_pkg::*;
#(
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  sncoStrobes_t       strobes,
  input  logic [BYTE_W-1:0]  wrData,
  output logic [ACC_W-1:0]   incWork,
  output logic [ACC_W-1:0]   accQ,
  output logic [PHASE_W-1:0] phaseOut
);
  logic [BYTES-2:0][BYTE_W-1:0] shadowQ;
  logic [ACC_W-1:0]             commitWord;

  for (genvar i = 0; i < BYTES - 1; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  shadowQ[i] <= '0;
      else if (strobes.byteWe[i]) shadowQ[i] <= wrData;
    end
  end

  // Top byte comes straight from the bus; lower bytes from the shadow.
  assign commitWord = {wrData, shadowQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               incWork <= '0;
    else if (strobes.commit) incWork <= commitWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              accQ <= '0;
    else if (strobes.clear) accQ <= '0;
    else                    accQ <= accQ + incWork;
  end

  assign phaseOut = accQ[ACC_W-1 -: PHASE_W];
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
  import snco_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h63,
  parameter int         PHASE_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [7:0]         wrAddr,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               phaseClr,
  output logic [ACC_W-1:0]   phaseAcc,
  output logic [PHASE_W-1:0] phaseOut
);
  sncoStrobes_t     strobes;
  logic [ACC_W-1:0] incWork;

  snco_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .phaseClr(phaseClr), .strobes(strobes)
  );

  snco_dp #(.PHASE_W(PHASE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .incWork(incWork), .accQ(phaseAcc), .phaseOut(phaseOut)
  );
endmodule

// File: rtl/snco_checker.sv
module snco_checker #(
  parameter logic [7:0] LO_ADDR = 8'h63,
  parameter logic [7:0] HI_ADDR = 8'h66
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [7:0]  wrAddr,
  input logic [7:0]  wrData,
  input logic        phaseClr,
  input logic [31:0] incWork,
  input logic [31:0] phaseAcc
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !phaseClr |=> phaseAcc == $past(phaseAcc) + $past(incWork));

  p_partial_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr >= LO_ADDR && wrAddr < HI_ADDR) |=> $stable(incWork));

  p_commit_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == HI_ADDR) |=> incWork[31:24] == $past(wrData));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseClr |=> phaseAcc == 32'd0);

  p_foreign_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr < LO_ADDR || wrAddr > HI_ADDR)) |=> $stable(incWork));
endmodule

bind subcarrier_nco snco_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .phaseClr(phaseClr), .incWork(incWork), .phaseAcc(phaseAcc)
);

// File: tb/subcarrier_nco_bench.sv
module subcarrier_nco_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = 8'h00;
  logic [7:0]  wrData = 8'h00;
  logic        phaseClr = 1'b0;
  logic [31:0] phaseAcc;
  logic [9:0]  phaseOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  subcarrier_nco u_subcarrier_nco (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .phaseClr(phaseClr), .phaseAcc(phaseAcc), .phaseOut(phaseOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Write three low bytes then top byte; returns at negedge after commit.
  task automatic loadInc(input logic [31:0] v);
    writeByte(8'h63, v[7:0]);
    writeByte(8'h64, v[15:8]);
    writeByte(8'h65, v[23:16]);
    writeByte(8'h66, v[31:24]);
  endtask

  task automatic clearPhase();
    phaseClr = 1'b1;
    @(negedge clk);
    phaseClr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 acc after reset", phaseAcc, 32'd0);
    check("R1 phase after reset", {22'd0, phaseOut}, 32'd0);
    tick(5);
    check("R1 acc idle with zero increment", phaseAcc, 32'd0);
  endtask

  task automatic t_partial_and_foreign();
    writeByte(8'h63, 8'h11);
    writeByte(8'h64, 8'h22);
    writeByte(8'h65, 8'h33);
    tick(3);
    check("R4 low-byte writes do not move acc", phaseAcc, 32'd0);
    writeByte(8'h62, 8'h55);
    writeByte(8'h67, 8'h77);
    writeByte(8'hE6, 8'h99);
    tick(3);
    check("R8 foreign addresses do not move acc", phaseAcc, 32'd0);
  endtask

  task automatic t_commit();
    loadInc(32'h21F07C1F);
    check("R5 step at commit edge uses old increment", phaseAcc, 32'd0);
    tick(1);
    check("R3 R5 byte order and new increment", phaseAcc, 32'h21F07C1F);
    tick(1);
    check("R2 second step", phaseAcc, 32'h43E0F83E);
  endtask

  task automatic t_line(input string req, input logic [31:0] inc, input real fsc, input int fllc);
    logic [31:0] expAcc;
    real ideal;
    logic [31:0] idealMod;
    int diff;
    int bound;
    loadInc(inc);
    clearPhase();
    check({req, " cleared start"}, phaseAcc, 32'd0);
    tick(fllc);
    expAcc = 32'(64'(fllc) * 64'(inc));
    check({req, " R2 exact line total"}, phaseAcc, expAcc);
    ideal = fsc * (2.0 ** 32);
    idealMod = 32'(longint'(ideal));
    diff = int'(phaseAcc - idealMod);
    if (diff < 0) diff = -diff;
    bound = fllc / 2;
    check({req, " within rounding bound"}, 32'(diff <= bound), 32'd1);
    check("R7 phase bits", {22'd0, phaseOut}, {22'd0, phaseAcc[31:22]});
  endtask

  task automatic t_wrap();
    loadInc(32'hFFFFFFFF);
    clearPhase();
    tick(1);
    check("R2 wrap step one", phaseAcc, 32'hFFFFFFFF);
    tick(1);
    check("R2 wrap step two", phaseAcc, 32'hFFFFFFFE);
    check("R7 phase at wrap", {22'd0, phaseOut}, 32'h3FF);
  endtask

  task automatic t_clear_priority();
    loadInc(32'h01000000);
    tick(3);
    clearPhase();
    check("R6 clear wins over add", phaseAcc, 32'd0);
    tick(1);
    check("R6 resumes after clear", phaseAcc, 32'h01000000);
    writeByte(8'h63, 8'hAA);
    check("R4 step unchanged after low write", phaseAcc, 32'h02000000);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_partial_and_foreign();
    t_commit();
    t_line("R9 525-line", 32'h21F07C1F, 227.5, 1716);
    t_line("R9 625-line", 32'h2A098ACB, 283.7516, 1728);
    t_wrap();
    t_clear_priority();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule